// File: doc/BRIEF.md
# Video RAM CPU Write Port

This block is the processor-facing write path of a small tile-based video display processor. The processor reaches it through two strobed 8-bit ports. The control port takes a two-byte address setup. The data port takes bytes meant for video memory. Each data byte that the block accepts goes out on a one-cycle synchronous memory write. The internal address then steps forward by one, so a block of bytes fills consecutive locations.

The display engine uses most memory cycles while it draws. The processor may therefore only write at a certain rate, and that rate depends on the display mode and on whether the picture is blanked. The block models this as a minimum spacing, counted in clock cycles, between accepted data writes. A data strobe that comes too soon is thrown away without any signal to the sender, and the address does not move. Every later byte therefore lands one location lower than intended. A running count of lost bytes is provided for test.

Top module: `vram_wr_port`

## Requirements
- R1: After reset, mem_we_o is low, drop_cnt_o is zero and writes are disabled, so a data strobe before any address setup makes no memory write and no drop.
- R2: An address is set by two control strobes. The first carries address bits 7:0. In the second, bits 5:0 carry address bits 13:8 and bit 6 set to 1 enables writes.
- R3: An accepted data strobe produces, one cycle later, a single-cycle mem_we_o with mem_addr_o equal to the current address and mem_wdata_o equal to the strobed byte. The address then advances by one.
- R4: The address wraps from 0x3FFF to 0x0000 on increment.
- R5: When the second control byte has bit 6 clear, the address is loaded but data strobes make no write and are not counted as drops until a setup with bit 6 set arrives.
- R6: Any data strobe resets the control byte sequencer, so the next control strobe is taken as a low address byte.
- R7: In the tiled modes (mode_i 0 and 1), with blank_i low, a data strobe is accepted only when it comes at least GAP_GFX cycles (default 29) after the last accepted one.
- R8: In text mode (mode_i 2) and multicolour mode (mode_i 3), with blank_i low, the minimum spacing is GAP_TXT cycles (default 13).
- R9: While blank_i is high, the minimum spacing is GAP_BLANK cycles (default 8), whatever the mode.
- R10: An enabled data strobe that comes too early makes no memory write, leaves the address unchanged and increments drop_cnt_o by one.
- R11: A control strobe in the same cycle as a data strobe is ignored, and the data strobe is handled normally.
- R12: The spacing is measured from the last accepted write and saturates. After a long idle time, the first data strobe is accepted at once, even right after an address setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control port write strobe |
| data_we_i | input | 1 | Data port write strobe |
| wdata_i | input | 8 | Byte on the port being strobed |
| mode_i | input | 2 | Display mode: 0/1 tiled, 2 text, 3 multicolour |
| blank_i | input | 1 | Vertical blanking or display disabled |
| mem_we_o | output | 1 | Memory write enable, one cycle per accepted byte |
| mem_addr_o | output | 14 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |
| drop_cnt_o | output | 16 | Count of data bytes lost to early arrival |

## Verification
Bursts are issued at spacings exactly at the mode's interval and one cycle below it. This tells the inclusive boundary apart from an off-by-one in each of the three interval choices. A burst at half the tiled interval must leave every other byte in consecutive locations, which separates "drop and hold the address" from "drop and advance". Interleaved control and data strobes, disabled setups, the top-of-memory wrap and collisions between the two ports each pin down the sequencer and address paths. A behavioural model compares every output on every clock.

// File: rtl/vwp_pkg.sv
package vwp_pkg;
  localparam int unsigned ADDR_W = 14;
  localparam int unsigned HI_W   = ADDR_W - 8;
  localparam int unsigned WR_BIT = 6;

  typedef logic [ADDR_W-1:0] vaddr_t;

  typedef enum logic [1:0] {
    MODE_GFX1  = 2'd0,
    MODE_GFX2  = 2'd1,
    MODE_TEXT  = 2'd2,
    MODE_MULTI = 2'd3
  } disp_mode_e;
endpackage

// File: rtl/vwp_ctrl_seq.sv
module vwp_ctrl_seq
  import vwp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic       data_we_i,
  input  logic [7:0] byte_i,
  input  logic       inc_i,
  output vaddr_t     addr_o,
  output logic       wr_en_o
);
  logic       second_q;
  logic [7:0] lo_q;
  vaddr_t     addr_q;
  logic       wr_en_q;

  // data strobe wins over a colliding control strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      lo_q     <= '0;
      addr_q   <= '0;
      wr_en_q  <= 1'b0;
    end else if (data_we_i) begin
      second_q <= 1'b0;
      if (inc_i) addr_q <= addr_q + vaddr_t'(1);
    end else if (ctrl_we_i) begin
      if (!second_q) begin
        lo_q     <= byte_i;
        second_q <= 1'b1;
      end else begin
        addr_q   <= {byte_i[HI_W-1:0], lo_q};
        wr_en_q  <= byte_i[WR_BIT];
        second_q <= 1'b0;
      end
    end
  end

  assign addr_o  = addr_q;
  assign wr_en_o = wr_en_q;

  // R3
  addr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> addr_q == $past(addr_q) + vaddr_t'(1));

  // R6
  phase_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> !second_q);

  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !inc_i) |=> $stable(addr_q));
endmodule

// File: rtl/vwp_gap_timer.sv
module vwp_gap_timer
  import vwp_pkg::*;
#(
  parameter int unsigned GAP_GFX   = 29,
  parameter int unsigned GAP_TXT   = 13,
  parameter int unsigned GAP_BLANK = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       blank_i,
  input  logic       acc_i,
  output logic       ok_o
);
  localparam int unsigned MAX_A   = (GAP_GFX > GAP_TXT) ? GAP_GFX : GAP_TXT;
  localparam int unsigned MAX_GAP = (MAX_A > GAP_BLANK) ? MAX_A : GAP_BLANK;
  localparam int unsigned SINCE_W = $clog2(MAX_GAP + 1);

  typedef logic [SINCE_W-1:0] cnt_t;

  cnt_t       since_q;
  cnt_t       gap_sel;
  disp_mode_e mode;

  assign mode = disp_mode_e'(mode_i);

  always_comb begin
    if (blank_i) begin
      gap_sel = cnt_t'(GAP_BLANK);
    end else begin
      unique case (mode)
        MODE_GFX1, MODE_GFX2:  gap_sel = cnt_t'(GAP_GFX);
        MODE_TEXT, MODE_MULTI: gap_sel = cnt_t'(GAP_TXT);
        default:               gap_sel = cnt_t'(GAP_GFX);
      endcase
    end
  end

  // cycles since last accepted write, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        since_q <= cnt_t'(MAX_GAP);
    else if (acc_i)                     since_q <= cnt_t'(1);
    else if (since_q < cnt_t'(MAX_GAP)) since_q <= since_q + cnt_t'(1);
  end

  assign ok_o = since_q >= gap_sel;

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> since_q == cnt_t'(1));

  // R12
  sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && since_q == cnt_t'(MAX_GAP)) |=> since_q == cnt_t'(MAX_GAP));
endmodule

// File: rtl/vram_wr_port.sv
module vram_wr_port
  import vwp_pkg::*;
#(
  parameter int unsigned GAP_GFX   = 29,
  parameter int unsigned GAP_TXT   = 13,
  parameter int unsigned GAP_BLANK = 8,
  parameter int unsigned DROP_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              data_we_i,
  input  logic [7:0]        wdata_i,
  input  logic [1:0]        mode_i,
  input  logic              blank_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  vaddr_t            addr;
  logic              wr_en;
  logic              gap_ok;
  logic              accept;
  logic              drop;
  logic              mem_we_q;
  vaddr_t            mem_addr_q;
  logic [7:0]        mem_wdata_q;
  logic [DROP_W-1:0] drop_q;

  assign accept = data_we_i && wr_en && gap_ok;
  assign drop   = data_we_i && wr_en && !gap_ok;

  vwp_ctrl_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we_i),
    .data_we_i (data_we_i),
    .byte_i    (wdata_i),
    .inc_i     (accept),
    .addr_o    (addr),
    .wr_en_o   (wr_en)
  );

  vwp_gap_timer #(
    .GAP_GFX   (GAP_GFX),
    .GAP_TXT   (GAP_TXT),
    .GAP_BLANK (GAP_BLANK)
  ) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .blank_i (blank_i),
    .acc_i   (accept),
    .ok_o    (gap_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      drop_q      <= '0;
    end else begin
      mem_we_q <= accept;
      if (accept) begin
        mem_addr_q  <= addr;
        mem_wdata_q <= wdata_i;
      end
      if (drop) drop_q <= drop_q + 1'b1;
    end
  end

  assign mem_we_o    = mem_we_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_wdata_q;
  assign drop_cnt_o  = drop_q;

  // R3
  we_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(data_we_i));

  // R5
  no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !wr_en) |=> (!mem_we_o && $stable(drop_cnt_o)));

  // R10
  drop_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && wr_en && !gap_ok) |=> (drop_cnt_o == $past(drop_cnt_o) + 1'b1 && !mem_we_o));

  // R7
  we_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

// File: tb/vram_wr_port_tb_top.sv
module vram_wr_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_GFX    = 29;
  localparam int GAP_TXT    = 13;
  localparam int GAP_BLANK  = 8;
  localparam int SINCE_MAX  = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic        data_we = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [1:0]  mode = 2'd0;
  logic        blank = 1'b0;
  logic        mem_we;
  logic [13:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [15:0] drop_cnt;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  bit done = 1'b0;
  byte vram [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_wr_port dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctrl_we_i   (ctrl_we),
    .data_we_i   (data_we),
    .wdata_i     (wdata),
    .mode_i      (mode),
    .blank_i     (blank),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .drop_cnt_o  (drop_cnt)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_addr, m_lo, m_since, m_drop;
  bit  m_wen, m_second, m_acc, e_we;
  int  e_addr, e_data;

  function automatic int gap_len();
    if (blank) return GAP_BLANK;
    return (mode < 2) ? GAP_GFX : GAP_TXT;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_lo = 0; m_since = SINCE_MAX; m_drop = 0;
      m_wen = 0; m_second = 0; e_we = 0; e_addr = 0; e_data = 0;
    end else begin
      m_acc = 0;
      e_we  = 0;
      if (data_we) begin
        m_second = 0;
        if (m_wen) begin
          if (m_since >= gap_len()) begin
            m_acc = 1; e_we = 1; e_addr = m_addr; e_data = wdata;
            m_addr = (m_addr + 1) % 16384;
          end else begin
            m_drop = (m_drop + 1) % 65536;
          end
        end
      end else if (ctrl_we) begin
        if (!m_second) begin
          m_lo = wdata; m_second = 1;
        end else begin
          m_addr = (wdata % 64) * 256 + m_lo;
          m_wen = wdata[6];
          m_second = 0;
        end
      end
      if (m_acc) m_since = 1;
      else if (m_since < SINCE_MAX) m_since++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_we == e_we, "R3 model we", mem_we, e_we);
      if (e_we) begin
        chk(mem_addr == e_addr[13:0], "R3 model addr", mem_addr, e_addr);
        chk(mem_wdata == e_data[7:0], "R3 model data", mem_wdata, e_data);
      end
      chk(drop_cnt == m_drop[15:0], "R10 model drop", drop_cnt, m_drop);
      if (mem_we) begin
        vram[int'(mem_addr)] = mem_wdata;
        wr_cnt++;
      end
    end
  end

  // stimulus tasks: entered and left at a falling edge
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctrl(logic [7:0] b);
    ctrl_we = 1'b1; wdata = b;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic dwr(logic [7:0] b, int sp);
    data_we = 1'b1; wdata = b;
    @(negedge clk);
    data_we = 1'b0;
    idle(sp - 1);
  endtask

  task automatic setup(int a, bit en);
    ctrl(8'(a % 256));
    ctrl({1'b0, en, 6'(a / 256)});
  endtask

  function automatic int rd(int a);
    if (vram.exists(a)) return int'(vram[a]) & 8'hFF;
    return -1;
  endfunction

  initial begin
    int d0, w0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(mem_we == 1'b0, "R1 we after reset", mem_we, 0);
    chk(drop_cnt == 16'd0, "R1 drop after reset", drop_cnt, 0);
    dwr(8'hEE, 4);
    idle(2);
    chk(wr_cnt == 0, "R1 strobe before setup", wr_cnt, 0);
    chk(drop_cnt == 16'd0, "R1 no drop before setup", drop_cnt, 0);

    // R7 R10 R2: half-interval burst in tiled mode loses every other byte
    mode = 2'd0;
    setup(16'h0000, 1);
    idle(40);
    d0 = drop_cnt;
    for (int i = 0; i < 8; i++) dwr(8'(8'hA0 + i), 16);
    idle(40);
    for (int i = 0; i < 4; i++)
      chk(rd(i) == 8'hA0 + 2 * i, "R10 packed bytes", rd(i), 8'hA0 + 2 * i);
    chk(drop_cnt == d0 + 4, "R10 drop count", drop_cnt, d0 + 4);

    // R7 boundary at 29 and 28
    mode = 2'd1;
    setup(16'h0100, 1);
    idle(40);
    d0 = drop_cnt;
    for (int i = 0; i < 3; i++) dwr(8'(8'h10 + i), GAP_GFX);
    idle(40);
    chk(drop_cnt == d0, "R7 spacing 29 no drop", drop_cnt, d0);
    chk(rd(16'h0102) == 8'h12, "R7 spacing 29 third byte", rd(16'h0102), 8'h12);
    dwr(8'h20, GAP_GFX - 1);
    dwr(8'h21, 40);
    dwr(8'h22, 40);
    chk(drop_cnt == d0 + 1, "R7 spacing 28 drop", drop_cnt, d0 + 1);
    chk(rd(16'h0104) == 8'h22, "R7 address held after drop", rd(16'h0104), 8'h22);

    // R8 text and multicolour
    for (int m = 2; m < 4; m++) begin
      mode = 2'(m);
      setup(16'h0300 + (m - 2) * 16'h0100, 1);
      idle(40);
      d0 = drop_cnt;
      for (int i = 0; i < 3; i++) dwr(8'(8'h30 + i), GAP_TXT);
      idle(20);
      chk(drop_cnt == d0, "R8 spacing 13 no drop", drop_cnt, d0);
      chk(rd(16'h0302 + (m - 2) * 16'h0100) == 8'h32, "R8 third byte",
          rd(16'h0302 + (m - 2) * 16'h0100), 8'h32);
      dwr(8'h40, GAP_TXT - 1);
      dwr(8'h41, 20);
      chk(drop_cnt == d0 + 1, "R8 spacing 12 drop", drop_cnt, d0 + 1);
    end

    // R9 blanking
    mode = 2'd0;
    blank = 1'b1;
    setup(16'h0500, 1);
    idle(40);
    d0 = drop_cnt;
    for (int i = 0; i < 3; i++) dwr(8'(8'h50 + i), GAP_BLANK);
    idle(20);
    chk(drop_cnt == d0, "R9 spacing 8 no drop", drop_cnt, d0);
    chk(rd(16'h0502) == 8'h52, "R9 third byte", rd(16'h0502), 8'h52);
    dwr(8'h60, GAP_BLANK - 1);
    dwr(8'h61, 20);
    chk(drop_cnt == d0 + 1, "R9 spacing 7 drop", drop_cnt, d0 + 1);
    blank = 1'b0;

    // R4 wrap
    setup(16'h3FFF, 1);
    idle(40);
    dwr(8'h11, 40);
    dwr(8'h22, 40);
    chk(rd(16'h3FFF) == 8'h11, "R4 top byte", rd(16'h3FFF), 8'h11);
    chk(rd(0) == 8'h22, "R4 wrapped byte", rd(0), 8'h22);

    // R5 bit 6 clear disables writes
    setup(16'h0600, 0);
    idle(40);
    w0 = wr_cnt; d0 = drop_cnt;
    dwr(8'h71, 40);
    dwr(8'h72, 4);
    idle(4);
    chk(wr_cnt == w0, "R5 no write when disabled", wr_cnt, w0);
    chk(drop_cnt == d0, "R5 no drop when disabled", drop_cnt, d0);
    setup(16'h0600, 1);
    dwr(8'h5A, 40);
    chk(rd(16'h0600) == 8'h5A, "R5 enabled again", rd(16'h0600), 8'h5A);

    // R6 data strobe resets sequencer
    setup(16'h0700, 1);
    idle(40);
    ctrl(8'h34);
    dwr(8'h77, 40);
    ctrl(8'h10);
    ctrl(8'h45);
    idle(40);
    dwr(8'h99, 40);
    chk(rd(16'h0700) == 8'h77, "R6 byte at old address", rd(16'h0700), 8'h77);
    chk(rd(16'h0510) == 8'h99, "R6 new setup decoded", rd(16'h0510), 8'h99);

    // R11 collision
    setup(16'h0800, 1);
    idle(40);
    ctrl_we = 1'b1; data_we = 1'b1; wdata = 8'h3C;
    @(negedge clk);
    ctrl_we = 1'b0; data_we = 1'b0;
    idle(39);
    dwr(8'h3D, 40);
    chk(rd(16'h0800) == 8'h3C, "R11 collided byte", rd(16'h0800), 8'h3C);
    chk(rd(16'h0801) == 8'h3D, "R11 next byte", rd(16'h0801), 8'h3D);

    // R12 long idle then immediate write after setup
    idle(300);
    setup(16'h0900, 1);
    dwr(8'hC3, 4);
    chk(rd(16'h0900) == 8'hC3, "R12 immediate write", rd(16'h0900), 8'hC3);

    // R2 full 14-bit address decode
    setup(16'h2A5C, 1);
    idle(40);
    dwr(8'hE1, 4);
    chk(rd(16'h2A5C) == 8'hE1, "R2 address decode", rd(16'h2A5C), 8'hE1);

    idle(5);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule